// File: doc/BRIEF.md
# USB Host Channel Transfer Tracker

This block follows the progress of a single USB host channel transfer. Before the channel runs, software loads three fields: a two-bit data PID, a packet count and a byte length, along with the transfer direction. A start strobe then arms the channel. While it is active, the block does three things:

- It advances the PID after every accepted packet.
- It counts packets down on each successful handshake.
- It counts bytes down each time a packet moves through the data FIFO.

On IN transfers, the PID carried by a received packet is compared with the expected PID. A mismatch raises a sticky data-toggle error, and the packet is not counted. When the packet count reaches zero, the channel raises a done flag and disables itself.

The packet engine and the FIFO logic sit next to this block and feed it with strobes. All outputs are registered, so an event sampled at one clock edge is visible on the outputs just after that edge.

Top module: `usb_chan_xfer_tracker`

## Requirements
- R1: After reset the PID reads 00, both counters read 0, and the error, done and active outputs are all 0.
- R2: A `cfg_we` pulse while the channel is inactive loads the PID, packet count, byte length and direction at that edge, and clears the error and done flags. A `cfg_we` pulse while the channel is active changes no output.
- R3: The PID encoding is 00 = DATA0, 10 = DATA1 and 11 = SETUP, with 01 reserved. A `start` pulse while inactive sets `active` and clears `done`. A `start` pulse while active has no effect.
- R4: An accepted packet advances the PID as follows: DATA1 becomes DATA0, and any other value (DATA0, SETUP or reserved) becomes DATA1.
- R5: An accepted packet decrements the packet count by exactly one. A packet is accepted when all of these hold: the channel is active, `pkt_ok` is high, `pkt_nak` is low, the count is nonzero, and, for IN transfers, `rx_pid` equals the current PID.
- R6: `pkt_nak` takes priority over `pkt_ok`. A NAKed packet leaves both the PID and the packet count unchanged.
- R7: On an IN transfer (direction bit 1), a `pkt_ok` whose `rx_pid` differs from the current PID sets `tog_err`. That packet changes neither the PID nor the count, and `tog_err` stays set until the next load. On an OUT transfer (direction bit 0), `rx_pid` is ignored.
- R8: A `fifo_mv` pulse while active subtracts `fifo_bytes` from the byte length, saturating at 0 rather than wrapping. A `fifo_mv` pulse while inactive has no effect.
- R9: An accepted packet taken at a count of 1 sets `done` and clears `active` at that same edge. If the channel is started with a count of 0, it goes to done and inactive one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the channel fields |
| cfg_dir_in | input | 1 | Direction to load: 1 = IN, 0 = OUT |
| cfg_pid | input | 2 | Initial PID to load |
| cfg_pkts | input | PKT_W | Packet count to load |
| cfg_len | input | LEN_W | Byte length to load |
| start | input | 1 | Channel enable strobe |
| pkt_ok | input | 1 | Packet completed with a successful handshake |
| pkt_nak | input | 1 | Packet was NAKed |
| rx_pid | input | 2 | PID seen on the received packet |
| fifo_mv | input | 1 | A packet moved through the data FIFO |
| fifo_bytes | input | SZ_W | Byte size of the moved packet |
| cur_pid | output | 2 | Current expected or transmitted PID |
| pkt_left | output | PKT_W | Packets remaining |
| len_left | output | LEN_W | Bytes remaining |
| tog_err | output | 1 | Sticky data-toggle error |
| xfer_done | output | 1 | Transfer completed |
| active | output | 1 | Channel is enabled |

## Verification
Directed sequences run the following cases:
- an OUT transfer that starts in SETUP, to separate SETUP→DATA1 from a plain toggle;
- an IN transfer with a deliberately wrong `rx_pid`, to separate mismatch handling from NAK handling;
- a single oversized FIFO move, which exposes wrap versus saturation;
- a zero-count start, which isolates the self-disable path.

Randomised phases then mix directions, initial PIDs, NAKs, mismatches, FIFO moves and `cfg_we` writes made while the channel is active. This distinguishes correct event priority and per-direction behaviour from designs that ignore the active gate or count rejected packets.

// File: rtl/usbch_pkg.sv
package usbch_pkg;
   typedef enum logic [1:0] {
      PID_DATA0 = 2'b00,
      PID_RSVD  = 2'b01,
      PID_DATA1 = 2'b10,
      PID_SETUP = 2'b11
   } pid_e;
endpackage

// File: rtl/usbch_pid_tracker.sv
module usbch_pid_tracker
   import usbch_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [1:0] load_pid,
   input  logic       adv,
   output logic [1:0] pid_o
);
   pid_e pid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pid_q <= PID_DATA0;
      else if (load)
         pid_q <= pid_e'(load_pid);
      else if (adv)
         pid_q <= (pid_q == PID_DATA1) ? PID_DATA0 : PID_DATA1;
   end

   assign pid_o = pid_q;
endmodule

// File: rtl/usbch_pkt_counter.sv
module usbch_pkt_counter #(
   parameter int PKT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PKT_W-1:0] load_val,
   input  logic             dec,
   output logic [PKT_W-1:0] cnt,
   output logic             is_zero,
   output logic             is_one
);
   localparam logic [PKT_W-1:0] ONE = PKT_W'(1);

   logic [PKT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && cnt_q != '0)
         cnt_q <= cnt_q - ONE;
   end

   assign cnt     = cnt_q;
   assign is_zero = (cnt_q == '0);
   assign is_one  = (cnt_q == ONE);
endmodule

// File: rtl/usbch_byte_counter.sv
module usbch_byte_counter #(
   parameter int LEN_W = 19,
   parameter int SZ_W  = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             sub,
   input  logic [SZ_W-1:0]  sz,
   output logic [LEN_W-1:0] cnt
);
   logic [LEN_W-1:0] sz_ext;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] nxt_sub;

   generate
      if (SZ_W == LEN_W) begin : g_same
         assign sz_ext = sz;
      end else begin : g_ext
         assign sz_ext = {{(LEN_W-SZ_W){1'b0}}, sz};
      end
   endgenerate

   // saturating subtraction: never wraps below zero
   assign nxt_sub = (cnt_q >= sz_ext) ? (cnt_q - sz_ext) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (sub)
         cnt_q <= nxt_sub;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/usb_chan_xfer_tracker.sv
module usb_chan_xfer_tracker #(
   parameter int PKT_W = 10,
   parameter int LEN_W = 19,
   parameter int SZ_W  = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_dir_in,
   input  logic [1:0]       cfg_pid,
   input  logic [PKT_W-1:0] cfg_pkts,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             start,
   input  logic             pkt_ok,
   input  logic             pkt_nak,
   input  logic [1:0]       rx_pid,
   input  logic             fifo_mv,
   input  logic [SZ_W-1:0]  fifo_bytes,
   output logic [1:0]       cur_pid,
   output logic [PKT_W-1:0] pkt_left,
   output logic [LEN_W-1:0] len_left,
   output logic             tog_err,
   output logic             xfer_done,
   output logic             active
);
   generate
      if (PKT_W < 1 || LEN_W < 1 || SZ_W < 1) begin : g_bad_w
         $error("usb_chan_xfer_tracker: widths must be at least 1");
      end
      if (SZ_W > LEN_W) begin : g_bad_sz
         $error("usb_chan_xfer_tracker: SZ_W must not exceed LEN_W");
      end
   endgenerate

   logic dir_q;
   logic err_q;
   logic done_q;
   logic act_q;
   logic cnt_zero;
   logic cnt_one;
   logic load_ok;
   logic try_pkt;
   logic mism;
   logic accept;
   logic finish;

   assign load_ok = cfg_we && !act_q;
   assign try_pkt = act_q && pkt_ok && !pkt_nak && !cnt_zero;
   assign mism    = try_pkt && dir_q && (rx_pid != cur_pid);
   assign accept  = try_pkt && !mism;
   assign finish  = act_q && (cnt_zero || (accept && cnt_one));

   usbch_pid_tracker u_pid (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_ok),
      .load_pid (cfg_pid),
      .adv      (accept),
      .pid_o    (cur_pid)
   );

   usbch_pkt_counter #(.PKT_W(PKT_W)) u_pkt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_ok),
      .load_val (cfg_pkts),
      .dec      (accept),
      .cnt      (pkt_left),
      .is_zero  (cnt_zero),
      .is_one   (cnt_one)
   );

   usbch_byte_counter #(.LEN_W(LEN_W), .SZ_W(SZ_W)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_ok),
      .load_val (cfg_len),
      .sub      (act_q && fifo_mv),
      .sz       (fifo_bytes),
      .cnt      (len_left)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= 1'b0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         if (load_ok) begin
            dir_q  <= cfg_dir_in;
            err_q  <= 1'b0;
            done_q <= 1'b0;
         end
         if (mism)
            err_q <= 1'b1;
         if (!act_q && start) begin
            act_q  <= 1'b1;
            done_q <= 1'b0;
         end else if (finish) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign tog_err   = err_q;
   assign xfer_done = done_q;
   assign active    = act_q;
endmodule

// File: rtl/usbch_xfer_checker.sv
module usbch_xfer_checker #(
   parameter int PKT_W = 10,
   parameter int LEN_W = 19
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic             pkt_ok,
   input logic             pkt_nak,
   input logic [1:0]       rx_pid,
   input logic             fifo_mv,
   input logic             dir_q,
   input logic [1:0]       cur_pid,
   input logic [PKT_W-1:0] pkt_left,
   input logic [LEN_W-1:0] len_left,
   input logic             tog_err,
   input logic             xfer_done,
   input logic             active
);
   logic good_pkt;
   assign good_pkt = active && pkt_ok && !pkt_nak && pkt_left != '0 &&
                     (!dir_q || rx_pid == cur_pid);

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!active && !tog_err && !xfer_done));

   assert_cfg_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cfg_we && !pkt_ok && !fifo_mv) |=>
      ($stable(cur_pid) && $stable(pkt_left) && $stable(len_left)));

   assert_pid_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (good_pkt && cur_pid != 2'b10) |=> (cur_pid == 2'b10));

   assert_pkt_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      good_pkt |=> (pkt_left == $past(pkt_left) - 1'b1));

   assert_nak_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && pkt_nak) |=> ($stable(cur_pid) && $stable(pkt_left)));

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_err && !(cfg_we && !active)) |=> tog_err);

   assert_len_nowrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && fifo_mv) |=> (len_left <= $past(len_left)));

   assert_done_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> !active);
endmodule

bind usb_chan_xfer_tracker usbch_xfer_checker #(.PKT_W(PKT_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .pkt_ok    (pkt_ok),
   .pkt_nak   (pkt_nak),
   .rx_pid    (rx_pid),
   .fifo_mv   (fifo_mv),
   .dir_q     (dir_q),
   .cur_pid   (cur_pid),
   .pkt_left  (pkt_left),
   .len_left  (len_left),
   .tog_err   (tog_err),
   .xfer_done (xfer_done),
   .active    (active)
);

// File: tb/usb_chan_xfer_tracker_test.sv
module usb_chan_xfer_tracker_test;
   localparam int PKT_W = 10;
   localparam int LEN_W = 19;
   localparam int SZ_W  = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic             cfg_dir_in = 1'b0;
   logic [1:0]       cfg_pid = 2'b00;
   logic [PKT_W-1:0] cfg_pkts = '0;
   logic [LEN_W-1:0] cfg_len = '0;
   logic             start = 1'b0;
   logic             pkt_ok = 1'b0;
   logic             pkt_nak = 1'b0;
   logic [1:0]       rx_pid = 2'b00;
   logic             fifo_mv = 1'b0;
   logic [SZ_W-1:0]  fifo_bytes = '0;
   logic [1:0]       cur_pid;
   logic [PKT_W-1:0] pkt_left;
   logic [LEN_W-1:0] len_left;
   logic             tog_err;
   logic             xfer_done;
   logic             active;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference model state
   logic [1:0]       m_pid = 2'b00;
   logic [PKT_W-1:0] m_pkts = '0;
   logic [LEN_W-1:0] m_len = '0;
   logic             m_dir = 1'b0;
   logic             m_err = 1'b0;
   logic             m_done = 1'b0;
   logic             m_act = 1'b0;

   always #5 clk = ~clk;

   usb_chan_xfer_tracker #(.PKT_W(PKT_W), .LEN_W(LEN_W), .SZ_W(SZ_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dir_in(cfg_dir_in),
      .cfg_pid(cfg_pid), .cfg_pkts(cfg_pkts), .cfg_len(cfg_len), .start(start),
      .pkt_ok(pkt_ok), .pkt_nak(pkt_nak), .rx_pid(rx_pid), .fifo_mv(fifo_mv),
      .fifo_bytes(fifo_bytes), .cur_pid(cur_pid), .pkt_left(pkt_left),
      .len_left(len_left), .tog_err(tog_err), .xfer_done(xfer_done), .active(active)
   );

   function automatic logic [1:0] next_pid(input logic [1:0] p);
      return (p == 2'b10) ? 2'b00 : 2'b10;
   endfunction

   function automatic logic [LEN_W-1:0] sat_sub(input logic [LEN_W-1:0] a,
                                                input logic [SZ_W-1:0] b);
      logic [LEN_W-1:0] bx;
      bx = LEN_W'(b);
      return (a >= bx) ? a - bx : '0;
   endfunction

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      logic try_p, mis, acc;
      logic [PKT_W-1:0] p0;
      try_p = m_act && pkt_ok && !pkt_nak && (m_pkts != '0);
      mis   = try_p && m_dir && (rx_pid != m_pid);
      acc   = try_p && !mis;
      p0    = m_pkts;
      if (!m_act && cfg_we) begin
         m_pid = cfg_pid; m_pkts = cfg_pkts; m_len = cfg_len;
         m_dir = cfg_dir_in; m_err = 1'b0; m_done = 1'b0;
      end
      if (acc) begin
         m_pid  = next_pid(m_pid);
         m_pkts = m_pkts - 1'b1;
      end
      if (mis) m_err = 1'b1;
      if (m_act && fifo_mv) m_len = sat_sub(m_len, fifo_bytes);
      if (!m_act && start) begin
         m_act = 1'b1; m_done = 1'b0;
      end else if (m_act && (p0 == '0 || (acc && p0 == 1))) begin
         m_act = 1'b0; m_done = 1'b1;
      end
   endtask

   task automatic check_all();
      chk("R4", "cur_pid", cur_pid, m_pid);
      chk("R5", "pkt_left", pkt_left, m_pkts);
      chk("R8", "len_left", len_left, m_len);
      chk("R7", "tog_err", tog_err, m_err);
      chk("R9", "xfer_done", xfer_done, m_done);
      chk("R3", "active", active, m_act);
   endtask

   task automatic step();
      @(posedge clk);
      model_step();
      #1;
      check_all();
      cfg_we = 1'b0; start = 1'b0; pkt_ok = 1'b0; pkt_nak = 1'b0;
      fifo_mv = 1'b0;
   endtask

   task automatic load(input logic dir, input logic [1:0] pid,
                       input int pk, input int ln);
      cfg_we = 1'b1; cfg_dir_in = dir; cfg_pid = pid;
      cfg_pkts = PKT_W'(pk); cfg_len = LEN_W'(ln);
      step();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #2;
      chk("R1", "reset cur_pid", cur_pid, 0);
      chk("R1", "reset pkt_left", pkt_left, 0);
      chk("R1", "reset len_left", len_left, 0);
      chk("R1", "reset flags", {tog_err, xfer_done, active}, 0);
      repeat (2) @(posedge clk);
      #3 rst_n = 1'b1;
      #3;

      // R2/R3: load then start, OUT transfer beginning in SETUP (11)
      load(1'b0, 2'b11, 3, 100);
      chk("R2", "loaded pid", cur_pid, 3);
      chk("R2", "loaded len", len_left, 100);
      start = 1'b1; step();
      chk("R3", "active after start", active, 1);
      // R4: SETUP -> DATA1 on OUT, rx_pid ignored (R7)
      pkt_ok = 1'b1; rx_pid = 2'b01; step();
      chk("R4", "SETUP becomes DATA1", cur_pid, 2);
      // R2: write while active ignored
      cfg_we = 1'b1; cfg_pkts = 10'd77; cfg_len = 19'd5; cfg_pid = 2'b00; step();
      chk("R2", "pkts unchanged while active", pkt_left, 2);
      chk("R2", "len unchanged while active", len_left, 100);
      // R6: NAK has priority
      pkt_ok = 1'b1; pkt_nak = 1'b1; step();
      chk("R6", "NAK pid held", cur_pid, 2);
      chk("R6", "NAK count held", pkt_left, 2);
      // R8: oversized move saturates
      fifo_mv = 1'b1; fifo_bytes = 11'd60; step();
      fifo_mv = 1'b1; fifo_bytes = 11'd60; step();
      chk("R8", "length saturates at zero", len_left, 0);
      pkt_ok = 1'b1; step();
      pkt_ok = 1'b1; step();
      chk("R9", "done at zero", xfer_done, 1);
      chk("R9", "self disabled", active, 0);
      // R8: move while inactive ignored
      fifo_mv = 1'b1; fifo_bytes = 11'd1; step();

      // R7: IN mismatch
      load(1'b1, 2'b00, 2, 64);
      chk("R2", "done cleared by load", xfer_done, 0);
      start = 1'b1; step();
      pkt_ok = 1'b1; rx_pid = 2'b10; step();
      chk("R7", "mismatch flags error", tog_err, 1);
      chk("R7", "mismatch keeps count", pkt_left, 2);
      pkt_ok = 1'b1; rx_pid = 2'b00; step();
      chk("R7", "error sticky", tog_err, 1);
      chk("R5", "match decrements", pkt_left, 1);
      // restart guard R3: start while active ignored
      start = 1'b1; step();

      // R9: zero count start
      pkt_ok = 1'b1; rx_pid = 2'b10; step();
      load(1'b0, 2'b00, 0, 8);
      start = 1'b1; step();
      chk("R9", "zero start active one cycle", active, 1);
      step();
      chk("R9", "zero start done", xfer_done, 1);

      // random phases
      for (int ph = 0; ph < 60; ph++) begin
         logic [1:0] ip;
         ip = ($urandom % 3 == 0) ? 2'b11 : (($urandom % 2) ? 2'b10 : 2'b00);
         load(1'($urandom), ip, int'($urandom % 7), int'($urandom % 4000));
         start = 1'b1; step();
         for (int c = 0; c < 30; c++) begin
            int r;
            r = int'($urandom % 100);
            pkt_ok  = (r < 50);
            pkt_nak = (r >= 40 && r < 55);
            rx_pid  = ($urandom % 5 == 0) ? 2'($urandom) : m_pid;
            fifo_mv = ($urandom % 3 == 0);
            fifo_bytes = SZ_W'($urandom % 1100);
            if ($urandom % 10 == 0) begin
               cfg_we = 1'b1; cfg_pkts = PKT_W'($urandom); cfg_len = LEN_W'($urandom);
               cfg_pid = 2'($urandom); cfg_dir_in = 1'($urandom);
            end
            step();
         end
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule